// File: doc/BRIEF.md
# Serial Wire Debug Host Transaction Engine

This block is the host side of a two-pin serial debug link. It takes one register access at a time from a command port and carries it out over a clock pin and a bidirectional data pin. Each command names a debug-port or access-port register with a 2-bit address. It is either a read or a write and, for a write, carries a 32-bit word. A separate flush command is also accepted. When the access is finished, the block returns one response with the read word and a status code.

The engine builds the 8-bit request and switches the data pin between driving and released for the turnaround bits. It decodes the 3-bit acknowledge and checks the read parity. When the target answers WAIT, the engine repeats the whole access from the request onward without help, up to a programmable retry limit. Any other error becomes a sticky status. That status blocks all later accesses until a flush reports it and clears it. After an access-port transfer the engine gives a programmable number of idle clocks, so the target can finish the transfer internally.

Top module: `swd_xact_engine`

## Requirements
- R1: The request is sent least significant bit first. bit0 = 1 (start), bit1 = access-port select, bit2 = read select, bit3 = address bit 0, bit4 = address bit 1, bit5 = XOR of bits 1 to 4, bit6 = 0, bit7 = 1 (park).
- R2: The clock pin stays low for `cfg_half_div` system cycles and high for `cfg_half_div` system cycles (0 acts as 1). The pin outputs change only when the clock falls. Input bits are taken on the system edge where the clock rises.
- R3: A successful read uses 46 clock pulses: 8 request bits, then the pin is released for 1 turnaround, 3 acknowledge, 32 data, 1 parity and 1 turnaround bit. The data arrives LSB first and is returned with status 0 (OK).
- R4: A successful write uses 46 clock pulses: 8 request bits, then turnaround, 3 acknowledge and turnaround with the pin released. After that the host drives 32 data bits LSB first and then the XOR of the data bits. The status is 0.
- R5: The acknowledge is a 3-bit value whose first received bit is bit 0. WAIT (3'b010) makes the engine resend the same request and repeat the full access.
- R6: With `cfg_retry_max` = N (N not 0), a WAIT after N repeats ends the access with status 4 (TIMEOUT) and makes that status sticky. With N = 0 there is no limit.
- R7: FAULT (3'b100) gives status 1. Any other value that is not OK (3'b001) gives status 2 (PROTOCOL). Either one becomes sticky. A write stops after its second turnaround (13 clock pulses).
- R8: A read whose parity bit differs from the XOR of its 32 data bits returns status 3 (PARITY) and read data 0, and makes that status sticky.
- R9: While a sticky status is held, read and write commands complete without any clock pulse. They return the sticky status and read data 0.
- R10: A flush gives 8 clock pulses with the data pin released. It then returns the sticky status and clears it to OK.
- R11: An access-port transfer that succeeds is followed by `cfg_idle_clks` clock pulses with the pin released. A debug-port transfer has none.
- R12: After reset the clock is low, the data pin is driven low, no response is pending and a command is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Engine idle; the command is taken on this edge |
| cmd_flush | input | 1 | Command is a flush |
| cmd_ap | input | 1 | 1 = access-port register, 0 = debug-port register |
| cmd_rnw | input | 1 | 1 = read, 0 = write |
| cmd_addr | input | 2 | Register address bits |
| cmd_wdata | input | 32 | Write word |
| cfg_half_div | input | 8 | System cycles per clock half period |
| cfg_idle_clks | input | 8 | Idle clocks after access-port transfers |
| cfg_retry_max | input | 8 | WAIT repeat limit, 0 = unlimited |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_rdata | output | 32 | Read word (0 unless a read succeeded) |
| rsp_status | output | 3 | 0 OK, 1 FAULT, 2 PROTOCOL, 3 PARITY, 4 TIMEOUT |
| swclk | output | 1 | Serial clock pin |
| swdio_out | output | 1 | Data pin output value |
| swdio_oe | output | 1 | Data pin output enable |
| swdio_in | input | 1 | Data pin input value |

## Verification
The hardest case to reach is a chain of WAIT answers that either ends in success or hits the retry limit. The test also has to show that the sticky status then stops all pin activity until a flush. The bench contains a target model that reacts to the clock pin and answers each attempt from a scripted list of acknowledges. This lets it return two WAITs followed by OK, or WAIT on every attempt, with a chosen retry limit. It also counts clock pulses and request headers, so an extra replay or a skipped access changes a count the bench can see.

// File: rtl/swd_xact_pkg.sv
package swd_xact_pkg;

    localparam int WORD_W     = 32;
    localparam int REQ_BITS   = 8;
    localparam int FLUSH_CLKS = 8;

    localparam logic [2:0] ACK_OK    = 3'b001;
    localparam logic [2:0] ACK_WAIT  = 3'b010;
    localparam logic [2:0] ACK_FAULT = 3'b100;

    typedef enum logic [2:0] {
        ST_OK      = 3'd0,
        ST_FAULT   = 3'd1,
        ST_PROTO   = 3'd2,
        ST_PARITY  = 3'd3,
        ST_TIMEOUT = 3'd4
    } swd_status_e;

    typedef enum logic [3:0] {
        PH_IDLE, PH_REQ, PH_TRN1, PH_ACK, PH_RDATA,
        PH_TRN2, PH_WDATA, PH_IDLEC, PH_DONE
    } swd_phase_e;

    typedef struct packed {
        logic              ap;
        logic              rnw;
        logic [1:0]        addr;
        logic [WORD_W-1:0] wdata;
    } swd_cmd_t;

    // Header, transmitted bit 0 first.
    function automatic logic [7:0] build_request(logic ap, logic rnw, logic [1:0] addr);
        return {1'b1, 1'b0, ap ^ rnw ^ addr[0] ^ addr[1], addr[1], addr[0], rnw, ap, 1'b1};
    endfunction

    function automatic swd_status_e ack_to_status(logic [2:0] ack);
        return (ack == ACK_FAULT) ? ST_FAULT : ST_PROTO;
    endfunction

endpackage

// File: rtl/swd_clk_gen.sv
module swd_clk_gen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [DIV_W-1:0] half_div,
    output logic             swclk,
    output logic             rise_stb,
    output logic             fall_stb
);
    logic [DIV_W-1:0] cnt_q;
    logic             hi_q;
    logic [DIV_W-1:0] lim;
    logic             last;

    assign lim      = (half_div == '0) ? '0 : half_div - 1'b1;
    assign last     = en && (cnt_q >= lim);
    assign rise_stb = last && !hi_q;
    assign fall_stb = last && hi_q;
    assign swclk    = hi_q;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            cnt_q <= '0;
            hi_q  <= 1'b0;
        end else if (last) begin
            cnt_q <= '0;
            hi_q  <= ~hi_q;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R9: a stopped timer leaves the clock pin low.
    assert_clk_low_when_off_R9: assert property (@(posedge clk) disable iff (rst)
        !en |=> !swclk);

endmodule

// File: rtl/swd_xact_seq.sv
module swd_xact_seq
    import swd_xact_pkg::*;
#(
    parameter int IDLE_W  = 8,
    parameter int RETRY_W = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cmd_valid,
    output logic               cmd_ready,
    input  logic               cmd_flush,
    input  swd_cmd_t           cmd,
    input  logic [IDLE_W-1:0]  idle_cycles,
    input  logic [RETRY_W-1:0] retry_limit,
    input  logic               rise_stb,
    input  logic               fall_stb,
    input  logic               swdio_in,
    output logic               run,
    output logic               swdio_out,
    output logic               swdio_oe,
    output logic               rsp_valid,
    output logic [WORD_W-1:0]  rsp_rdata,
    output swd_status_e        rsp_status
);
    localparam int BIT_IW = $clog2(WORD_W + 1);
    localparam int CNT_W  = (IDLE_W > BIT_IW) ? IDLE_W : BIT_IW;

    swd_phase_e         ph_q;
    swd_cmd_t           cmd_q;
    logic               flush_q;
    logic [CNT_W-1:0]   cnt_q;
    logic [2:0]         ack_q;
    logic [WORD_W:0]    rbits_q;
    logic [RETRY_W-1:0] retry_q;
    swd_status_e        sticky_q;
    swd_status_e        status_q;
    logic [WORD_W-1:0]  rdata_q;

    logic [7:0]         req_byte;
    logic [WORD_W:0]    wbits;
    logic [CNT_W-1:0]   idle_target;
    swd_phase_e         post_ph;
    logic               rd_par_bad;

    assign req_byte    = build_request(cmd_q.ap, cmd_q.rnw, cmd_q.addr);
    assign wbits       = {^cmd_q.wdata, cmd_q.wdata};
    assign idle_target = flush_q ? CNT_W'(FLUSH_CLKS) : CNT_W'(idle_cycles);
    assign post_ph     = (cmd_q.ap && idle_cycles != '0) ? PH_IDLEC : PH_DONE;
    assign rd_par_bad  = rbits_q[WORD_W] != ^rbits_q[WORD_W-1:0];

    assign cmd_ready  = (ph_q == PH_IDLE);
    assign run        = (ph_q != PH_IDLE) && (ph_q != PH_DONE);
    assign rsp_valid  = (ph_q == PH_DONE);
    assign rsp_rdata  = rdata_q;
    assign rsp_status = status_q;

    always_comb begin
        swdio_oe  = 1'b1;
        swdio_out = 1'b0;
        case (ph_q)
            PH_REQ:   swdio_out = req_byte[cnt_q[2:0]];
            PH_WDATA: swdio_out = wbits[cnt_q[BIT_IW-1:0]];
            PH_TRN1, PH_ACK, PH_RDATA, PH_TRN2, PH_IDLEC: swdio_oe = 1'b0;
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q     <= PH_IDLE;
            cmd_q    <= '0;
            flush_q  <= 1'b0;
            cnt_q    <= '0;
            ack_q    <= '0;
            rbits_q  <= '0;
            retry_q  <= '0;
            sticky_q <= ST_OK;
            status_q <= ST_OK;
            rdata_q  <= '0;
        end else begin
            if (rise_stb) begin
                if (ph_q == PH_ACK)   ack_q[cnt_q[1:0]] <= swdio_in;
                if (ph_q == PH_RDATA) rbits_q[cnt_q[BIT_IW-1:0]] <= swdio_in;
            end
            case (ph_q)
                PH_IDLE: if (cmd_valid) begin
                    cmd_q    <= cmd;
                    flush_q  <= cmd_flush;
                    cnt_q    <= '0;
                    retry_q  <= '0;
                    rdata_q  <= '0;
                    status_q <= sticky_q;
                    if (cmd_flush)               ph_q <= PH_IDLEC;
                    else if (sticky_q != ST_OK)  ph_q <= PH_DONE;
                    else                         ph_q <= PH_REQ;
                end
                PH_DONE: begin
                    ph_q <= PH_IDLE;
                    if (flush_q) sticky_q <= ST_OK;
                end
                default: if (fall_stb) begin
                    cnt_q <= cnt_q + 1'b1;
                    case (ph_q)
                        PH_REQ: if (cnt_q == CNT_W'(REQ_BITS - 1)) begin
                            ph_q  <= PH_TRN1;
                            cnt_q <= '0;
                        end
                        PH_TRN1: begin
                            ph_q  <= PH_ACK;
                            cnt_q <= '0;
                        end
                        PH_ACK: if (cnt_q == CNT_W'(2)) begin
                            ph_q  <= cmd_q.rnw ? PH_RDATA : PH_TRN2;
                            cnt_q <= '0;
                        end
                        PH_RDATA: if (cnt_q == CNT_W'(WORD_W)) begin
                            ph_q  <= PH_TRN2;
                            cnt_q <= '0;
                        end
                        PH_TRN2: begin
                            cnt_q <= '0;
                            if (ack_q == ACK_WAIT) begin
                                if (retry_limit != '0 && retry_q == retry_limit) begin
                                    sticky_q <= ST_TIMEOUT;
                                    status_q <= ST_TIMEOUT;
                                    ph_q     <= PH_DONE;
                                end else begin
                                    retry_q <= retry_q + 1'b1;
                                    ph_q    <= PH_REQ;
                                end
                            end else if (ack_q != ACK_OK) begin
                                sticky_q <= ack_to_status(ack_q);
                                status_q <= ack_to_status(ack_q);
                                ph_q     <= PH_DONE;
                            end else if (cmd_q.rnw && rd_par_bad) begin
                                sticky_q <= ST_PARITY;
                                status_q <= ST_PARITY;
                                ph_q     <= PH_DONE;
                            end else if (!cmd_q.rnw) begin
                                ph_q <= PH_WDATA;
                            end else begin
                                rdata_q  <= rbits_q[WORD_W-1:0];
                                status_q <= ST_OK;
                                ph_q     <= post_ph;
                            end
                        end
                        PH_WDATA: if (cnt_q == CNT_W'(WORD_W)) begin
                            cnt_q    <= '0;
                            status_q <= ST_OK;
                            ph_q     <= post_ph;
                        end
                        PH_IDLEC: if (cnt_q == idle_target - 1'b1) begin
                            ph_q <= PH_DONE;
                        end
                        default: ;
                    endcase
                end
            endcase
        end
    end

    // R3: a response lasts exactly one cycle.
    assert_rsp_single_R3: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> !rsp_valid);

    // R8: a response that is not OK never carries read data.
    assert_err_no_data_R8: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_status != ST_OK) |-> (rsp_rdata == '0));

    // R9: with a sticky error, a read or write goes straight to the response.
    assert_skip_when_sticky_R9: assert property (@(posedge clk) disable iff (rst)
        (cmd_ready && cmd_valid && !cmd_flush && sticky_q != ST_OK) |=> rsp_valid);

    // R10: a flush response leaves the sticky status cleared.
    assert_flush_clears_R10: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && flush_q) |=> (sticky_q == ST_OK));

    // R6: the repeat counter never passes a non-zero limit.
    assert_retry_bound_R6: assert property (@(posedge clk) disable iff (rst)
        (!cmd_ready && retry_limit != '0) |-> (retry_q <= retry_limit));

endmodule

// File: rtl/swd_xact_engine.sv
module swd_xact_engine
    import swd_xact_pkg::*;
#(
    parameter int DIV_W   = 8,
    parameter int IDLE_W  = 8,
    parameter int RETRY_W = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cmd_valid,
    output logic               cmd_ready,
    input  logic               cmd_flush,
    input  logic               cmd_ap,
    input  logic               cmd_rnw,
    input  logic [1:0]         cmd_addr,
    input  logic [31:0]        cmd_wdata,
    input  logic [DIV_W-1:0]   cfg_half_div,
    input  logic [IDLE_W-1:0]  cfg_idle_clks,
    input  logic [RETRY_W-1:0] cfg_retry_max,
    output logic               rsp_valid,
    output logic [31:0]        rsp_rdata,
    output logic [2:0]         rsp_status,
    output logic               swclk,
    output logic               swdio_out,
    output logic               swdio_oe,
    input  logic               swdio_in
);
    swd_cmd_t    cmd_s;
    swd_status_e status_s;
    logic        run, rise_stb, fall_stb;

    assign cmd_s      = '{ap: cmd_ap, rnw: cmd_rnw, addr: cmd_addr, wdata: cmd_wdata};
    assign rsp_status = status_s;

    swd_clk_gen #(.DIV_W(DIV_W)) i_clk_gen (
        .clk      (clk),
        .rst      (rst),
        .en       (run),
        .half_div (cfg_half_div),
        .swclk    (swclk),
        .rise_stb (rise_stb),
        .fall_stb (fall_stb)
    );

    swd_xact_seq #(.IDLE_W(IDLE_W), .RETRY_W(RETRY_W)) i_seq (
        .clk         (clk),
        .rst         (rst),
        .cmd_valid   (cmd_valid),
        .cmd_ready   (cmd_ready),
        .cmd_flush   (cmd_flush),
        .cmd         (cmd_s),
        .idle_cycles (cfg_idle_clks),
        .retry_limit (cfg_retry_max),
        .rise_stb    (rise_stb),
        .fall_stb    (fall_stb),
        .swdio_in    (swdio_in),
        .run         (run),
        .swdio_out   (swdio_out),
        .swdio_oe    (swdio_oe),
        .rsp_valid   (rsp_valid),
        .rsp_rdata   (rsp_rdata),
        .rsp_status  (status_s)
    );

    // R2: the pin outputs hold still for the whole high half of the clock.
    assert_data_stable_high_R2: assert property (@(posedge clk) disable iff (rst)
        (swclk && $past(swclk)) |-> ($stable(swdio_out) && $stable(swdio_oe)));

endmodule

// File: tb/test_swd_xact_engine.sv
module test_swd_xact_engine;
    timeunit 1ns;
    timeprecision 1ps;

    logic        clk = 1'b0;
    logic        rst;
    logic        cmd_valid, cmd_ready, cmd_flush, cmd_ap, cmd_rnw;
    logic [1:0]  cmd_addr;
    logic [31:0] cmd_wdata;
    logic [7:0]  cfg_half_div, cfg_idle_clks, cfg_retry_max;
    logic        rsp_valid;
    logic [31:0] rsp_rdata;
    logic [2:0]  rsp_status;
    logic        swclk, swdio_out, swdio_oe, swdio_in;

    always #2.5 clk = ~clk;

    swd_xact_engine i_swd_xact_engine (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_flush(cmd_flush), .cmd_ap(cmd_ap), .cmd_rnw(cmd_rnw),
        .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .cfg_half_div(cfg_half_div),
        .cfg_idle_clks(cfg_idle_clks), .cfg_retry_max(cfg_retry_max),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_status(rsp_status),
        .swclk(swclk), .swdio_out(swdio_out), .swdio_oe(swdio_oe), .swdio_in(swdio_in)
    );

    int n_tests = 0;
    int n_fail  = 0;

    // Target model script and observations.
    logic [2:0]  tgt_ack [0:7];
    int          tgt_nack = 0;
    logic [2:0]  tgt_final_ack = 3'b001;
    int          tgt_attempt = 0;
    int          tgt_reqs = 0;
    logic [31:0] tgt_rdata = '0;
    logic        tgt_badpar = 1'b0;
    logic [7:0]  tgt_req = '0;
    logic [32:0] tgt_wbits = '0;

    int edge_cnt = 0;
    int hi_run = 0;
    int last_hi = 0;

    logic [31:0] got_rdata;
    logic [2:0]  got_status;
    int          got_edges;

    always @(posedge swclk) edge_cnt = edge_cnt + 1;

    always @(posedge clk) begin
        if (swclk) hi_run = hi_run + 1;
        else if (hi_run != 0) begin
            last_hi = hi_run;
            hi_run  = 0;
        end
    end

    initial begin : target
        swdio_in = 1'b1;
        forever begin : tgt_loop
            logic [7:0]  r;
            logic [2:0]  a;
            logic [32:0] d;
            @(posedge swclk);
            if (swdio_oe && swdio_out) begin
                r[0] = 1'b1;
                for (int i = 1; i < 8; i++) begin
                    @(posedge swclk);
                    r[i] = swdio_out;
                end
                tgt_req  = r;
                tgt_reqs = tgt_reqs + 1;
                a = (tgt_attempt < tgt_nack) ? tgt_ack[tgt_attempt] : tgt_final_ack;
                tgt_attempt = tgt_attempt + 1;
                @(posedge swclk);
                for (int i = 0; i < 3; i++) begin
                    @(negedge swclk);
                    swdio_in = a[i];
                    @(posedge swclk);
                end
                if (r[2]) begin
                    d = {(^tgt_rdata) ^ tgt_badpar, tgt_rdata};
                    for (int i = 0; i < 33; i++) begin
                        @(negedge swclk);
                        swdio_in = d[i];
                        @(posedge swclk);
                    end
                    @(negedge swclk);
                    swdio_in = 1'b1;
                    @(posedge swclk);
                end else begin
                    @(negedge swclk);
                    swdio_in = 1'b1;
                    @(posedge swclk);
                    if (a == 3'b001) begin
                        for (int i = 0; i < 33; i++) begin
                            @(posedge swclk);
                            d[i] = swdio_out;
                        end
                        tgt_wbits = d;
                    end
                end
            end
        end
    end

    function automatic logic [7:0] exp_req(logic ap, logic rnw, logic [1:0] a);
        logic [7:0] v;
        v[0] = 1'b1; v[1] = ap; v[2] = rnw; v[3] = a[0]; v[4] = a[1];
        v[5] = ap ^ rnw ^ a[0] ^ a[1]; v[6] = 1'b0; v[7] = 1'b1;
        return v;
    endfunction

    task automatic check(input string tag, input string what, input longint act, input longint exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic script(input int n, input logic [2:0] a0, input logic [2:0] a1,
                          input logic [2:0] fin, input logic [31:0] rd, input logic bad);
        tgt_nack = n; tgt_ack[0] = a0; tgt_ack[1] = a1; tgt_final_ack = fin;
        tgt_attempt = 0; tgt_rdata = rd; tgt_badpar = bad;
    endtask

    task automatic run_cmd(input logic fl, input logic ap, input logic rnw,
                           input logic [1:0] addr, input logic [31:0] wd);
        @(negedge clk);
        edge_cnt = 0;
        cmd_valid = 1'b1; cmd_flush = fl; cmd_ap = ap; cmd_rnw = rnw;
        cmd_addr = addr; cmd_wdata = wd;
        @(negedge clk);
        cmd_valid = 1'b0;
        while (!rsp_valid) @(negedge clk);
        got_rdata = rsp_rdata; got_status = rsp_status; got_edges = edge_cnt;
    endtask

    task automatic t_reset;
        check("R12", "swclk", swclk, 0);
        check("R12", "rsp_valid", rsp_valid, 0);
        check("R12", "cmd_ready", cmd_ready, 1);
        check("R12", "swdio_oe", swdio_oe, 1);
        check("R12", "swdio_out", swdio_out, 0);
    endtask

    task automatic t_dp_read;
        script(0, 3'b001, 3'b001, 3'b001, 32'hA5C3_0F96, 1'b0);
        run_cmd(1'b0, 1'b0, 1'b1, 2'b10, 32'h0);
        check("R3", "status", got_status, 0);
        check("R3", "rdata", got_rdata, 32'hA5C3_0F96);
        check("R3", "clocks", got_edges, 46);
        check("R1", "request", tgt_req, exp_req(1'b0, 1'b1, 2'b10));
        check("R2", "high width", last_hi, 2);
    endtask

    task automatic t_dp_write;
        logic [31:0] w;
        w = 32'h1357_9BDF;
        script(0, 3'b001, 3'b001, 3'b001, 32'h0, 1'b0);
        run_cmd(1'b0, 1'b0, 1'b0, 2'b01, w);
        check("R4", "status", got_status, 0);
        check("R4", "data+parity", tgt_wbits, {^w, w});
        check("R4", "clocks", got_edges, 46);
        check("R1", "request", tgt_req, exp_req(1'b0, 1'b0, 2'b01));
    endtask

    task automatic t_ap_idle;
        cfg_half_div = 8'd3;
        script(0, 3'b001, 3'b001, 3'b001, 32'h0BAD_F00D, 1'b0);
        run_cmd(1'b0, 1'b1, 1'b1, 2'b11, 32'h0);
        check("R11", "clocks with idle", got_edges, 49);
        check("R11", "rdata", got_rdata, 32'h0BAD_F00D);
        check("R1", "request", tgt_req, exp_req(1'b1, 1'b1, 2'b11));
        check("R2", "high width", last_hi, 3);
        cfg_half_div = 8'd2;
    endtask

    task automatic t_wait_retry;
        int r0;
        r0 = tgt_reqs;
        script(2, 3'b010, 3'b010, 3'b001, 32'h7E57_1234, 1'b0);
        run_cmd(1'b0, 1'b0, 1'b1, 2'b01, 32'h0);
        check("R5", "status", got_status, 0);
        check("R5", "headers sent", tgt_reqs - r0, 3);
        check("R5", "clocks", got_edges, 138);
        check("R5", "rdata", got_rdata, 32'h7E57_1234);
        check("R5", "repeated request", tgt_req, exp_req(1'b0, 1'b1, 2'b01));
    endtask

    task automatic t_fault_sticky_flush;
        int r0;
        script(0, 3'b001, 3'b001, 3'b100, 32'h0, 1'b0);
        run_cmd(1'b0, 1'b1, 1'b0, 2'b00, 32'hFFFF_0000);
        check("R7", "fault status", got_status, 1);
        check("R7", "write stop clocks", got_edges, 13);
        r0 = tgt_reqs;
        script(0, 3'b001, 3'b001, 3'b001, 32'h1111_2222, 1'b0);
        run_cmd(1'b0, 1'b0, 1'b1, 2'b00, 32'h0);
        check("R9", "skipped status", got_status, 1);
        check("R9", "skipped clocks", got_edges, 0);
        check("R9", "skipped headers", tgt_reqs - r0, 0);
        check("R9", "skipped rdata", got_rdata, 0);
        run_cmd(1'b1, 1'b0, 1'b0, 2'b00, 32'h0);
        check("R10", "flush status", got_status, 1);
        check("R10", "flush clocks", got_edges, 8);
        run_cmd(1'b0, 1'b0, 1'b1, 2'b00, 32'h0);
        check("R10", "status after flush", got_status, 0);
        check("R10", "rdata after flush", got_rdata, 32'h1111_2222);
    endtask

    task automatic t_parity;
        script(0, 3'b001, 3'b001, 3'b001, 32'hC0DE_0001, 1'b1);
        run_cmd(1'b0, 1'b0, 1'b1, 2'b11, 32'h0);
        check("R8", "parity status", got_status, 3);
        check("R8", "parity rdata", got_rdata, 0);
        run_cmd(1'b1, 1'b0, 1'b0, 2'b00, 32'h0);
        check("R8", "flushed status", got_status, 3);
    endtask

    task automatic t_proto;
        script(0, 3'b001, 3'b001, 3'b111, 32'h0, 1'b0);
        run_cmd(1'b0, 1'b0, 1'b1, 2'b00, 32'h0);
        check("R7", "protocol status", got_status, 2);
        run_cmd(1'b1, 1'b0, 1'b0, 2'b00, 32'h0);
        check("R7", "flushed protocol", got_status, 2);
    endtask

    task automatic t_timeout;
        int r0;
        cfg_retry_max = 8'd2;
        r0 = tgt_reqs;
        script(0, 3'b010, 3'b010, 3'b010, 32'h0, 1'b0);
        run_cmd(1'b0, 1'b0, 1'b1, 2'b10, 32'h0);
        check("R6", "timeout status", got_status, 4);
        check("R6", "attempts", tgt_reqs - r0, 3);
        check("R6", "clocks", got_edges, 138);
        run_cmd(1'b1, 1'b0, 1'b0, 2'b00, 32'h0);
        check("R6", "flushed timeout", got_status, 4);
        cfg_retry_max = 8'd0;
    endtask

    initial begin : watchdog
        #(200000 * 5);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin : main
        rst = 1'b1; cmd_valid = 1'b0; cmd_flush = 1'b0; cmd_ap = 1'b0; cmd_rnw = 1'b0;
        cmd_addr = 2'b00; cmd_wdata = '0;
        cfg_half_div = 8'd2; cfg_idle_clks = 8'd3; cfg_retry_max = 8'd0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset;
        t_dp_read;
        t_dp_write;
        t_ap_idle;
        t_wait_retry;
        t_fault_sticky_flush;
        t_parity;
        t_proto;
        t_timeout;
        repeat (4) @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule